// File: doc/BRIEF.md
# Two-Strobe Transmit Word FIFO

This block queues up to eight 31-bit words that wait for a serial line transmitter. A host with a 16-bit parallel bus builds each word from two writes. A first-half strobe captures the lower 16 bits, and a second-half strobe supplies the upper 15 bits. The second-half strobe is also the moment the whole word enters the queue. When the queue is full, the block drops further words without any error.

The transmitter reads the oldest word in show-ahead form on `pop_word` and advances the queue with a one-cycle `pop`. A ready flag is high while nothing is queued. A complementary availability flag tells the transmitter that a word is waiting. An asynchronous active-low reset, released in step with the clock, discards every queued word and any half-written word.

Top module: `txw_fifo`

## Requirements
- R1: While `rst_n` is low, and once reset has been released, `tx_ready` is 1 and `word_avail` is 0. Reset also discards a held first half, so a second-half strobe as the first strobe after reset queues nothing.
- R2: `lo_stb` captures `bus_data[15:0]` as word bits 15:0. A later `hi_stb` takes `bus_data[14:0]` as word bits 30:16 and ignores `bus_data[15]`. The word is queued on that `hi_stb` cycle and becomes visible on `word_avail`/`pop_word` from the next cycle.
- R3: A `hi_stb` with no first half held since the last commit or reset has no effect.
- R4: A repeated `lo_stb` replaces the held first half, and the following `hi_stb` uses the most recent one.
- R5: Each held first half serves one commit only, so a second `hi_stb` after a commit is ignored. When `lo_stb` and `hi_stb` are high in the same cycle, the first half is captured and `hi_stb` is ignored.
- R6: Words leave in the order they were queued.
- R7: The queue holds at most 8 words. A commit arriving while 8 words are held is dropped, even if `pop` is high in the same cycle, and the held words are unchanged.
- R8: `tx_ready` is 1 exactly when no word is held. `word_avail` is always its complement.
- R9: `pop` while the queue is empty has no effect.
- R10: A commit and a `pop` in the same cycle on a queue holding 1 to 7 words are both carried out. The count is unchanged and the order is kept.
- R11: `pop_word` shows the oldest held word without a pop. After a `pop`, it shows the next word from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 16 | Host data bus |
| lo_stb | input | 1 | First-half load strobe (one cycle per write) |
| hi_stb | input | 1 | Second-half load strobe, commits the word |
| pop | input | 1 | Transmitter takes the oldest word |
| pop_word | output | 31 | Oldest held word (show-ahead) |
| word_avail | output | 1 | At least one word held |
| tx_ready | output | 1 | Queue empty |

## Verification
The bench first sends a second-half strobe with no first half, then a second one straight after a commit. A design that commits on any second-half strobe would queue stale or garbage words. It then repeats the first half and strobes both halves in the same cycle, which catches a design that keeps the first captured half or commits on a simultaneous strobe. It fills the queue and tries a ninth word, both with and without a pop in the same cycle. An overflow bug there would overwrite the oldest word or wrap the count back to empty. Finally it pops an empty queue and combines a pop with a commit on a partly filled queue, where a wrong design would skip a pointer, lose a word or miscount the flags.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic {
    ASM_IDLE  = 1'b0,
    ASM_ARMED = 1'b1
  } asm_state_t;
endpackage

// File: rtl/txw_rst_sync.sv
module txw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/txw_assembler.sv
module txw_assembler #(
  parameter int BUS_W  = 16,
  parameter int WORD_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              lo_stb,
  input  logic              hi_stb,
  output logic              wr_req,
  output logic [WORD_W-1:0] wr_word,
  output logic              armed
);
  import txw_pkg::*;
  localparam int HI_W = WORD_W - BUS_W;

  asm_state_t state_q, state_d;
  logic [BUS_W-1:0] held_q;
  logic held_en;

  // next-state: a lone second-half strobe commits only when armed
  always_comb begin
    state_d = state_q;
    held_en = 1'b0;
    wr_req  = 1'b0;
    if (lo_stb) begin
      held_en = 1'b1;
      state_d = ASM_ARMED;
    end else if (hi_stb && state_q == ASM_ARMED) begin
      wr_req  = 1'b1;
      state_d = ASM_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ASM_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (held_en) held_q <= bus_data;
  end

  assign wr_word = {bus_data[HI_W-1:0], held_q};
  assign armed   = (state_q == ASM_ARMED);
endmodule

// File: rtl/txw_occupancy.sv
module txw_occupancy #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic             push_ok,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = wr_req && !full;
  assign pop_ok  = rd_req && !empty;

  always_comb begin
    count_d = count_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    if (push_ok) wptr_d = ptr_inc(wptr_q);
    if (pop_ok)  rptr_d = ptr_inc(rptr_q);
    case ({push_ok, pop_ok})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else begin
      count_q <= count_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
    end
  end

  assign count = count_q;
  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
endmodule

// File: rtl/txw_store.sv
module txw_store #(
  parameter int WORD_W = 31,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  slot_we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot_en
    assign slot_we[g] = we && (waddr == PTR_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/txw_fifo.sv
module txw_fifo #(
  parameter int BUS_W  = 16,
  parameter int WORD_W = 31,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              lo_stb,
  input  logic              hi_stb,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_word,
  output logic              word_avail,
  output logic              tx_ready
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              rst_ns;
  logic              wr_req, armed, push_ok, full, empty;
  logic [WORD_W-1:0] wr_word;
  logic [CNT_W-1:0]  count;
  logic [PTR_W-1:0]  wptr, rptr;

  txw_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  txw_assembler #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .bus_data (bus_data),
    .lo_stb   (lo_stb),
    .hi_stb   (hi_stb),
    .wr_req   (wr_req),
    .wr_word  (wr_word),
    .armed    (armed)
  );

  txw_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_req  (wr_req),
    .rd_req  (pop),
    .push_ok (push_ok),
    .full    (full),
    .empty   (empty),
    .count   (count),
    .wptr    (wptr),
    .rptr    (rptr)
  );

  txw_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (push_ok),
    .waddr (wptr),
    .wdata (wr_word),
    .raddr (rptr),
    .rdata (pop_word)
  );

  assign tx_ready   = empty;
  assign word_avail = !empty;
endmodule

// File: rtl/txw_fifo_chk.sv
module txw_fifo_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lo_stb,
  input logic             hi_stb,
  input logic             pop,
  input logic             tx_ready,
  input logic             word_avail,
  input logic             armed,
  input logic             wr_req,
  input logic             full,
  input logic [CNT_W-1:0] count
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> $stable(count)); // R7
  AST_COMMIT_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !full && !pop |=> count == $past(count) + 1'b1); // R2
  AST_ORPHAN_HI: assert property (@(posedge clk) disable iff (!rst_n)
    hi_stb && !lo_stb && !armed && !pop |=> $stable(count)); // R3
  AST_LO_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    lo_stb |=> armed); // R4
  AST_HI_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    hi_stb && !lo_stb |=> !armed); // R5
  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    lo_stb && hi_stb && !pop |=> $stable(count)); // R5
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && pop && !wr_req |=> tx_ready); // R9
  AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !full && pop && word_avail |=> $stable(count)); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({tx_ready, word_avail})); // R8
endmodule

bind txw_fifo txw_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_ns),
  .lo_stb     (lo_stb),
  .hi_stb     (hi_stb),
  .pop        (pop),
  .tx_ready   (tx_ready),
  .word_avail (word_avail),
  .armed      (armed),
  .wr_req     (wr_req),
  .full       (full),
  .count      (count)
);

// File: tb/sim_txw_fifo.sv
`timescale 1ns/1ps
module sim_txw_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_data;
  logic        lo_stb, hi_stb, pop;
  logic [30:0] pop_word;
  logic        word_avail, tx_ready;

  int total = 0;
  int bad   = 0;
  logic [30:0] exp_q [$];
  logic        m_armed;
  logic [15:0] m_lo;

  always #2.5 clk = ~clk;

  txw_fifo u0 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .lo_stb(lo_stb),
    .hi_stb(hi_stb), .pop(pop), .pop_word(pop_word),
    .word_avail(word_avail), .tx_ready(tx_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every accepted pop is compared against the scoreboard front
  always @(negedge clk) begin
    if (rst_n && pop && word_avail) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected pop", {1'b0, pop_word}, 32'h0);
      else begin
        logic [30:0] e;
        e = exp_q.pop_front();
        chk(pop_word == e, "R6 order", {1'b0, pop_word}, {1'b0, e});
      end
    end
  end

  // driver: one cycle of stimulus, model updated from the requirements
  task automatic cyc(input logic l, input logic h, input logic p, input logic [15:0] d);
    int n;
    n = exp_q.size();
    lo_stb = l; hi_stb = h; pop = p; bus_data = d;
    if (l) begin
      m_armed = 1'b1; m_lo = d;
    end else if (h && m_armed) begin
      m_armed = 1'b0;
      if (n < 8) exp_q.push_back({d[14:0], m_lo});
    end
    @(negedge clk);
    @(posedge clk); #1;
    lo_stb = 1'b0; hi_stb = 1'b0; pop = 1'b0; bus_data = 16'h0;
  endtask

  task automatic put(input logic [15:0] lo, input logic [15:0] hi);
    cyc(1'b1, 1'b0, 1'b0, lo);
    cyc(1'b0, 1'b1, 1'b0, hi);
  endtask

  task automatic flags(input string tag);
    chk(tx_ready == (exp_q.size() == 0), tag, {31'b0, tx_ready}, {31'b0, exp_q.size() == 0});
    chk(word_avail == (exp_q.size() != 0), tag, {31'b0, word_avail}, {31'b0, exp_q.size() != 0});
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) cyc(1'b0, 1'b0, 1'b1, 16'h0);
    flags(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    exp_q.delete();
    m_armed = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(tx_ready == 1'b1 && word_avail == 1'b0, "R1 in reset",
        {30'b0, tx_ready, word_avail}, 32'h2);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    lo_stb = 1'b0; hi_stb = 1'b0; pop = 1'b0; bus_data = 16'h0;
    m_armed = 1'b0; m_lo = 16'h0;
    do_reset();
    flags("R1 after reset");

    // R2: field placement, bus bit 15 ignored on the second half
    put(16'hA5C3, 16'hFFFF);
    flags("R2 visible");
    chk(pop_word == {15'h7FFF, 16'hA5C3}, "R2 word", {1'b0, pop_word}, {1'b0, 15'h7FFF, 16'hA5C3});
    drain("R2 drained");

    // R3: orphan second half
    cyc(1'b0, 1'b1, 1'b0, 16'h1234);
    flags("R3 orphan hi");

    // R4: repeated first half
    cyc(1'b1, 1'b0, 1'b0, 16'h1111);
    cyc(1'b1, 1'b0, 1'b0, 16'h2222);
    cyc(1'b0, 1'b1, 1'b0, 16'h0333);
    chk(pop_word == {15'h0333, 16'h2222}, "R4 latest half", {1'b0, pop_word}, {1'b0, 15'h0333, 16'h2222});
    drain("R4 drained");

    // R5: second hi after commit ignored; simultaneous strobes
    put(16'h00AA, 16'h0055);
    cyc(1'b0, 1'b1, 1'b0, 16'h7777);
    chk(exp_q.size() == 1, "R5 model", 32'(exp_q.size()), 32'd1);
    flags("R5 one word");
    cyc(1'b1, 1'b1, 1'b0, 16'hBEEF);
    flags("R5 both strobes");
    cyc(1'b0, 1'b1, 1'b0, 16'h0101);
    flags("R5 armed by both");
    drain("R5 drained");

    // R6, R7: fill, overflow, overflow with pop
    for (int i = 0; i < 8; i++) put(16'(16'h1000 + i), 16'(16'h0200 + i));
    flags("R7 full");
    put(16'hDEAD, 16'h0BAD);
    flags("R7 drop");
    cyc(1'b1, 1'b0, 1'b0, 16'hCAFE);
    cyc(1'b0, 1'b1, 1'b1, 16'h0F0F);
    chk(exp_q.size() == 7, "R7 drop with pop", 32'(exp_q.size()), 32'd7);
    flags("R7 after pop");
    drain("R6 drained");

    // R9: pop on empty, then a write pops correctly
    cyc(1'b0, 1'b0, 1'b1, 16'h0);
    flags("R9 empty pop");
    put(16'h4242, 16'h0024);
    chk(pop_word == {15'h0024, 16'h4242}, "R9 pointer kept", {1'b0, pop_word}, {1'b0, 15'h0024, 16'h4242});
    drain("R9 drained");

    // R10, R11: simultaneous push/pop, show-ahead
    put(16'h0001, 16'h0011);
    put(16'h0002, 16'h0022);
    put(16'h0003, 16'h0033);
    chk(pop_word == {15'h0011, 16'h0001}, "R11 head", {1'b0, pop_word}, {1'b0, 15'h0011, 16'h0001});
    cyc(1'b1, 1'b0, 1'b0, 16'h0004);
    cyc(1'b0, 1'b1, 1'b1, 16'h0044);
    chk(exp_q.size() == 3, "R10 count", 32'(exp_q.size()), 32'd3);
    flags("R10 flags");
    chk(pop_word == {15'h0022, 16'h0002}, "R11 next", {1'b0, pop_word}, {1'b0, 15'h0022, 16'h0002});
    drain("R10 drained");

    // R1: reset discards words and the held first half
    put(16'h5555, 16'h0555);
    cyc(1'b1, 1'b0, 1'b0, 16'h6666);
    do_reset();
    flags("R1 cleared");
    cyc(1'b0, 1'b1, 1'b0, 16'h0777);
    flags("R1 half discarded");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule